// File: doc/BRIEF.md
# Oversampling Resolution Averager

This block sits behind a 12-bit converter and turns its stream of raw results into output samples whose resolution is set by a 3-bit mode input. Two modes pass samples on at the full input rate, either at full width or truncated to 10 bits. Four modes accumulate groups of 4, 16, 64 or 256 raw samples for each channel. These produce one result of 13, 14, 15 or 16 bits per group. Every fourfold increase in group size adds one bit of resolution and divides the output rate by four.

Each raw sample arrives with a valid flag and a 4-bit channel number. Each channel keeps its own running sum and sample count, so channels may be interleaved in any order. An output is a one-cycle strobe with a 16-bit data field and the channel number of the sample that completed it. Changing the mode or pulsing the clear input discards every partial group.

Top module: `osr_averager`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0, out_data is 0 and out_chan is 0.
- R2: In mode 0, and also for mode codes 6 and 7, every accepted sample gives out_valid high on the next clock edge, with out_data equal to the raw 12-bit sample zero-extended to 16 bits.
- R3: In mode 1, every accepted sample gives an output on the next clock edge, with out_data equal to the raw sample shifted right by two bits (range 0 to 1023).
- R4: In modes 2, 3, 4 and 5, let k be mode minus 1. A channel produces an output only on the clock edge after its 4^k-th accepted sample. The output is the sum of those 4^k samples shifted right by k bits, giving 13, 14, 15 or 16 significant bits. With all samples at 4095, mode 5 gives 65520. No other cycle raises out_valid.
- R5: Accumulation is separate for each of the 16 channels. Interleaving samples of different channels does not disturb any channel's sum or count.
- R6: out_chan on an output equals the channel number of the sample that produced it.
- R7: When the effective mode differs from the one used on the previous cycle, all sums and counts are cleared. A sample arriving in that same cycle is the first of a new group under the new mode. Codes 6 and 7 count as mode 0.
- R8: soft_clr high clears all sums and counts. A sample presented in the same cycle is discarded, and out_valid is 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of all partial groups |
| mode | input | 3 | Resolution mode, codes 0 to 7 |
| in_valid | input | 1 | Raw sample present this cycle |
| in_chan | input | 4 | Channel of the raw sample |
| in_data | input | 12 | Raw sample value |
| out_valid | output | 1 | One-cycle strobe for a finished output |
| out_data | output | 16 | Output sample, held between strobes |
| out_chan | output | 4 | Channel of the output sample |

## Verification
A stale or corrupted sum for one channel does not show at once. It only appears when that channel's group completes, which can take up to 256 samples in mode 5. A count that is off by one shows as a strobe one sample early or late, and as a wrong value in out_data. For this reason the sweeps run every group size to completion, with interleaved channels. They also change the mode and pulse the clear in the middle of a group, so that leftover state shows up in the very next completed output.

// File: rtl/osr_averager.sv
module osr_averager #(
  parameter int RAW_W = 12,
  parameter int OUT_W = 16,
  parameter int NCH   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_clr,
  input  logic [2:0]               mode,
  input  logic                     in_valid,
  input  logic [$clog2(NCH)-1:0]   in_chan,
  input  logic [RAW_W-1:0]         in_data,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_data,
  output logic [$clog2(NCH)-1:0]   out_chan
);
  localparam int CH_W  = $clog2(NCH);
  localparam int MAX_K = OUT_W - RAW_W;
  localparam int CNT_W = 2 * MAX_K;
  localparam int ACC_W = RAW_W + CNT_W;

  logic [ACC_W-1:0] acc [NCH];
  logic [CNT_W-1:0] cnt [NCH];
  logic [2:0]       mode_q;

  logic [2:0] eff_mode;
  assign eff_mode = (mode > 3'd5) ? 3'd0 : mode;

  logic chg;
  assign chg = eff_mode != mode_q;

  logic [2:0] k;
  assign k = eff_mode - 3'd1;

  logic [CNT_W-1:0] grp_last;
  assign grp_last = CNT_W'((32'd1 << (2 * k)) - 32'd1);

  logic [ACC_W-1:0] acc_cur, sum_next;
  logic [CNT_W-1:0] cnt_cur;
  assign acc_cur  = chg ? '0 : acc[in_chan];
  assign cnt_cur  = chg ? '0 : cnt[in_chan];
  assign sum_next = acc_cur + ACC_W'(in_data);

  logic [OUT_W-1:0] avg;
  assign avg = OUT_W'(sum_next >> k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        acc[i] <= '0;
        cnt[i] <= '0;
      end
      mode_q    <= 3'd0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= 1'b0;
      mode_q    <= eff_mode;
      if (soft_clr || chg) begin
        for (int i = 0; i < NCH; i++) begin
          acc[i] <= '0;
          cnt[i] <= '0;
        end
      end
      if (in_valid && !soft_clr) begin
        if (eff_mode == 3'd0) begin
          out_valid <= 1'b1;
          out_data  <= OUT_W'(in_data);
          out_chan  <= in_chan;
        end else if (eff_mode == 3'd1) begin
          out_valid <= 1'b1;
          out_data  <= OUT_W'(in_data >> 2);
          out_chan  <= in_chan;
        end else if (cnt_cur == grp_last) begin
          out_valid    <= 1'b1;
          out_data     <= avg;
          out_chan     <= in_chan;
          acc[in_chan] <= '0;
          cnt[in_chan] <= '0;
        end else begin
          acc[in_chan] <= sum_next;
          cnt[in_chan] <= cnt_cur + CNT_W'(1);
        end
      end
    end
  end

  assert_strobe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && !$past(soft_clr)));

  assert_chan_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chan == $past(in_chan)));

  assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(eff_mode) == 3'd0) |-> (out_data == OUT_W'($past(in_data))));

  assert_truncated_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(eff_mode) == 3'd1) |-> (out_data < OUT_W'(1024)));

  assert_four_group_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(eff_mode) == 3'd2) |-> (out_data < OUT_W'(8192)));

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !out_valid);
endmodule

// File: tb/tb_osr_averager.sv
module tb_osr_averager;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_chan = 4'd0;
  logic [11:0] in_data = 12'd0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [3:0]  out_chan;

  osr_averager dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .mode(mode),
    .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int ref_sum [16];
  int ref_cnt [16];
  int ref_mode = 0;
  int cur_mode = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_ref();
    for (int i = 0; i < 16; i++) begin
      ref_sum[i] = 0;
      ref_cnt[i] = 0;
    end
  endtask

  task automatic step(input bit v, input int ch, input int d, input bit clr, input string tag);
    int em, kk, n, s, ev, ed;
    @(negedge clk);
    in_valid = v; in_chan = 4'(ch); in_data = 12'(d); soft_clr = clr; mode = 3'(cur_mode);
    em = (cur_mode > 5) ? 0 : cur_mode;
    ev = 0; ed = 0;
    if (clr || em != ref_mode) clear_ref();
    ref_mode = em;
    if (v && !clr) begin
      if (em == 0) begin ev = 1; ed = d; end
      else if (em == 1) begin ev = 1; ed = d / 4; end
      else begin
        kk = em - 1;
        n = 1 << (2 * kk);
        s = ref_sum[ch] + d;
        if (ref_cnt[ch] == n - 1) begin
          ev = 1; ed = s >> kk;
          ref_sum[ch] = 0; ref_cnt[ch] = 0;
        end else begin
          ref_sum[ch] = s; ref_cnt[ch]++;
        end
      end
    end
    @(posedge clk); #1;
    check(out_valid == ev, {tag, " valid"}, int'(out_valid), ev);
    if (ev) begin
      check(out_data == 16'(ed), {tag, " data"}, int'(out_data), ed);
      check(out_chan == 4'(ch), {tag, " chan R6"}, int'(out_chan), ch);
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_ref();
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 valid in reset", int'(out_valid), 0);
    check(out_data == 0, "R1 data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_valid == 0 && out_chan == 0, "R1 after reset", int'(out_valid), 0);

    // R2: passthrough sweep across channels and values, then codes 6 and 7
    cur_mode = 0;
    for (int ch = 0; ch < 16; ch++)
      for (int j = 0; j < 8; j++) step(1, ch, (ch * 257 + j * 511) % 4096, 0, "R2 mode0");
    step(1, 3, 4095, 0, "R2 max");
    step(1, 4, 0, 0, "R2 zero");
    step(0, 0, 77, 0, "R2 idle");
    cur_mode = 6;
    for (int j = 0; j < 10; j++) step(1, j, j * 409, 0, "R2 mode6");
    cur_mode = 7;
    for (int j = 0; j < 10; j++) step(1, 15 - j, 4095 - j * 13, 0, "R2 mode7");

    // R3: truncation
    cur_mode = 1;
    for (int j = 0; j < 64; j++) step(1, j % 16, (j * 67 + 3) % 4096, 0, "R3 mode1");
    step(1, 2, 4095, 0, "R3 max");
    step(1, 2, 3, 0, "R3 small");

    // R4: each averaging mode on one channel, with idle gaps
    for (int m = 2; m <= 5; m++) begin
      cur_mode = m;
      for (int j = 0; j < 2 * (1 << (2 * (m - 1))); j++) begin
        step(1, 5, (j * 37 + m) % 4096, 0, "R4 ramp");
        if (j % 7 == 0) step(0, 5, 0, 0, "R4 gap");
      end
    end
    cur_mode = 5;
    for (int j = 0; j < 256; j++) step(1, 9, 4095, 0, "R4 full scale");
    cur_mode = 2;
    for (int j = 0; j < 4; j++) step(1, 1, 4095, 0, "R4 mode2 max");

    // R5 and R6: interleaved channels
    cur_mode = 3;
    for (int j = 0; j < 64; j++) step(1, (j * 5) % 3 + 10, (j * 991) % 4096, 0, "R5 interleave");
    cur_mode = 2;
    for (int j = 0; j < 48; j++) step(1, (j * 7) % 16, (j * 131 + 17) % 4096, 0, "R5 scatter");

    // R7: mode change in the middle of a group
    cur_mode = 2;
    step(1, 0, 1000, 0, "R7 pre");
    step(1, 0, 2000, 0, "R7 pre");
    cur_mode = 3;
    for (int j = 0; j < 16; j++) step(1, 0, 100 + j, 0, "R7 fresh group");
    cur_mode = 2;
    step(1, 4, 4000, 0, "R7 pre");
    cur_mode = 6;
    step(0, 0, 0, 0, "R7 idle change");
    cur_mode = 2;
    for (int j = 0; j < 4; j++) step(1, 4, 8, 0, "R7 after idle change");

    // R8: soft clear mid group, sample in the clear cycle dropped
    cur_mode = 2;
    for (int j = 0; j < 3; j++) step(1, 6, 3000, 0, "R8 pre");
    step(1, 6, 3000, 1, "R8 clear cycle");
    for (int j = 0; j < 4; j++) step(1, 6, 12 * (j + 1), 0, "R8 after clear");
    cur_mode = 0;
    step(1, 2, 55, 1, "R8 clear passthrough");
    step(1, 2, 56, 0, "R8 resume");

    @(negedge clk);
    in_valid = 0; soft_clr = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule